// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that gives an external controller read and write access to a small bank of 8-bit configuration registers. A transfer begins when chip select goes low. The first 16 serial clocks carry an instruction word that names the direction, the byte count and the start address. A data phase of one to four bytes follows. Input bits are taken on the rising serial clock edge. Read bits change after a rising edge, so the controller can take them on the next falling edge.

Register 0 configures the port itself. One bit selects the bit order: most significant bit first, or least significant bit first. Another bit moves read data from the dedicated output pin to the shared data pin. A third bit returns every register to its default value and then clears itself. The port samples its serial pins with the system clock through synchronizers. The whole register image is presented in parallel to the rest of the chip.

Top module: `spi_reg_port`

## Requirements
- R1: After reset every register holds its default value, register 0 reads 0x10, and neither data output enable is asserted.
- R2: The instruction word is 16 bits. Bit 15 = 1 selects a read and 0 a write. Bits 14:13 = 00, 01, 10, 11 select 1, 2, 3 or 4 data bytes. The register index is the low log2(NUM_REGS) bits of bits 12:0, and the higher address bits are ignored.
- R3: On a write, each data bit is taken on a rising serial clock edge. Each completed byte is stored in the addressed register and appears on `regs_o`, at byte lane `8*index`.
- R4: On a read, the first data bit is presented after the 16th rising edge. Every further bit changes only after a rising edge and is stable at the falling edge that follows.
- R5: After each byte the address moves down by one in most-significant-first mode and up by one in least-significant-first mode, wrapping modulo NUM_REGS.
- R6: Register 0 bit 6 = 1 sends the instruction and the data least significant bit first. A new value of this bit applies from the next transfer onward.
- R7: Register 0 bit 7 = 0 puts read data on `sdo_out` with `sdo_oe` high and `sdio_oe` low. Bit 7 = 1 puts read data on `sdio_out` with `sdio_oe` high and `sdo_oe` low. The change applies from the next transfer.
- R8: Raising chip select before a byte completes discards the partial byte and restarts the bit count. The next transfer then works normally.
- R9: Writing 1 to register 0 bit 5 returns all registers, register 0 included, to their defaults. Bit 5 then reads 0.
- R10: Serial clocks beyond the counted bytes write nothing, and no output is driven during them.
- R11: Register 0 bit 4 always reads 1 and bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdio_in | input | 1 | Serial data from the controller (shared data pin, input side) |
| sdio_out | output | 1 | Read data for the shared data pin in bidirectional mode |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo_out | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Output enable for the dedicated output pin |
| regs_o | output | NUM_REGS*8 | Parallel image of the register bank; register i at bits 8*i+7:8*i |

## Verification
Each serial input passes through two synchronizer stages and one edge-detect stage before the engine acts on it, and read data takes one more cycle for the register fetch. A read bit is therefore due four system clocks after the rising serial edge that advances it. The bench holds each serial clock phase for ten system clocks and samples the outputs just before it drives the falling edge, well after that point. Stored values are checked on `regs_o` only after chip select has been high for several cycles, so every byte write has completed.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   localparam int INSTR_BITS   = 16;
   localparam int BYTE_BITS    = 8;
   localparam int CFG_BIDIR    = 7;
   localparam int CFG_LSB      = 6;
   localparam int CFG_SOFT_RST = 5;
   localparam logic [5:0] CFG_FIXED_LOW = 6'b010000;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_INSTR,
      PH_DATA,
      PH_DONE
   } phase_e;

   typedef struct packed {
      logic        is_read;
      logic [1:0]  len_code;
      logic [12:0] addr;
   } instr_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic cs_n_s,
   output logic sclk_rise,
   output logic sdi_s
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   // lane order: {cs_n, sclk, sdi}
   logic [STAGES-1:0][2:0] pipe;
   logic                   sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b100;
         sclk_q <= 1'b0;
      end else begin
         pipe[0] <= {cs_n, sclk, sdi};
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         sclk_q <= pipe[STAGES-1][1];
      end
   end

   assign cs_n_s    = pipe[STAGES-1][2];
   assign sdi_s     = pipe[STAGES-1][0];
   assign sclk_rise = pipe[STAGES-1][1] & ~sclk_q;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_regport_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_rise,
   input  logic              sdi_s,
   input  logic              cfg_lsb,
   input  logic              cfg_bidir,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              sdo_out,
   output logic              sdo_oe,
   output logic              sdio_out,
   output logic              sdio_oe
);

   localparam int CNT_W = $clog2(INSTR_BITS);

   phase_e            phase;
   logic              lsb_q;
   logic              bidir_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [INSTR_BITS-1:0] instr_sh;
   logic              is_rd;
   logic [1:0]        bytes_left;
   logic [ADDR_W-1:0] cur_addr;
   logic [7:0]        rx_sh;
   logic [7:0]        tx_sh;
   logic              fetch;
   logic              wr_en_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [7:0]        wr_data_q;

   logic [INSTR_BITS-1:0] instr_next;
   instr_t            iw;
   logic [7:0]        rx_next;
   logic [ADDR_W-1:0] addr_step;
   logic              tx_bit;
   logic              drive;

   always_comb begin
      instr_next = lsb_q ? {sdi_s, instr_sh[INSTR_BITS-1:1]}
                         : {instr_sh[INSTR_BITS-2:0], sdi_s};
      rx_next    = lsb_q ? {sdi_s, rx_sh[7:1]} : {rx_sh[6:0], sdi_s};
      addr_step  = lsb_q ? cur_addr + 1'b1 : cur_addr - 1'b1;
      tx_bit     = lsb_q ? tx_sh[0] : tx_sh[7];
   end

   assign iw = instr_t'(instr_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         lsb_q      <= 1'b0;
         bidir_q    <= 1'b0;
         bit_cnt    <= '0;
         instr_sh   <= '0;
         is_rd      <= 1'b0;
         bytes_left <= '0;
         cur_addr   <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         fetch      <= 1'b0;
         wr_en_q    <= 1'b0;
         wr_addr_q  <= '0;
         wr_data_q  <= '0;
      end else begin
         wr_en_q <= 1'b0;
         fetch   <= 1'b0;
         if (fetch) tx_sh <= rd_data;
         if (cs_n_s) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
         end else begin
            unique case (phase)
               PH_IDLE: begin
                  phase   <= PH_INSTR;
                  lsb_q   <= cfg_lsb;
                  bidir_q <= cfg_bidir;
                  bit_cnt <= '0;
               end
               PH_INSTR: if (sclk_rise) begin
                  instr_sh <= instr_next;
                  if (bit_cnt == CNT_W'(INSTR_BITS - 1)) begin
                     bit_cnt    <= '0;
                     is_rd      <= iw.is_read;
                     bytes_left <= iw.len_code;
                     cur_addr   <= iw.addr[ADDR_W-1:0];
                     fetch      <= iw.is_read;
                     phase      <= PH_DATA;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               PH_DATA: if (sclk_rise) begin
                  rx_sh <= rx_next;
                  if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
                     bit_cnt  <= '0;
                     cur_addr <= addr_step;
                     if (!is_rd) begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= cur_addr;
                        wr_data_q <= rx_next;
                     end
                     if (bytes_left == 2'd0) begin
                        phase <= PH_DONE;
                     end else begin
                        bytes_left <= bytes_left - 1'b1;
                        fetch      <= is_rd;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     tx_sh   <= lsb_q ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
                  end
               end
               PH_DONE: ;
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign rd_addr  = cur_addr;
   assign wr_en    = wr_en_q;
   assign wr_addr  = wr_addr_q;
   assign wr_data  = wr_data_q;

   assign drive    = !cs_n_s && (phase == PH_DATA) && is_rd;
   assign sdo_oe   = drive && !bidir_q;
   assign sdio_oe  = drive && bidir_q;
   assign sdo_out  = sdo_oe  ? tx_bit : 1'b0;
   assign sdio_out = sdio_oe ? tx_bit : 1'b0;

   assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (phase == PH_IDLE))
      else $error("chip select high did not return the engine to idle");

   assert_write_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(sclk_rise))
      else $error("register write without a preceding serial clock edge");

   assert_done_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE && $past(phase == PH_DONE)) |-> !wr_en)
      else $error("write issued after the counted bytes");

   assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && $past(phase != PH_IDLE)) |-> ($stable(lsb_q) && $stable(bidir_q)))
      else $error("port mode changed inside a transfer");

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int ADDR_W   = 4,
   parameter logic [NUM_REGS*8-1:0] DEFAULTS = {{(NUM_REGS-1){8'h00}}, 8'h10}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat,
   output logic                  cfg_lsb,
   output logic                  cfg_bidir
);

   localparam logic [NUM_REGS*8-1:0] RESET_IMAGE =
      {DEFAULTS[NUM_REGS*8-1:8], DEFAULTS[7:6], CFG_FIXED_LOW};

   logic [NUM_REGS-1:0][7:0] bank;
   logic                     soft_rst;

   assign soft_rst = wr_en && (wr_addr == '0) && wr_data[CFG_SOFT_RST];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == 0) begin : g_cfg
         logic [1:0] mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           mode_q <= DEFAULTS[7:6];
            else if (soft_rst)                    mode_q <= DEFAULTS[7:6];
            else if (wr_en && wr_addr == '0)      mode_q <= wr_data[7:6];
         end
         assign bank[g] = {mode_q, CFG_FIXED_LOW};
      end else begin : g_plain
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= DEFAULTS[g*8 +: 8];
            else if (soft_rst)                       q <= DEFAULTS[g*8 +: 8];
            else if (wr_en && wr_addr == ADDR_W'(g)) q <= wr_data;
         end
         assign bank[g] = q;
      end
   end

   assign rd_data   = bank[rd_addr];
   assign regs_flat = bank;
   assign cfg_lsb   = bank[0][CFG_LSB];
   assign cfg_bidir = bank[0][CFG_BIDIR];

   assert_soft_reset_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (regs_flat == RESET_IMAGE))
      else $error("soft reset did not restore the defaults");

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
   import spi_regport_pkg::*;
#(
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = {{(NUM_REGS-1){8'h00}}, 8'h10}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  sclk,
   input  logic                  sdio_in,
   output logic                  sdio_out,
   output logic                  sdio_oe,
   output logic                  sdo_out,
   output logic                  sdo_oe,
   output logic [NUM_REGS*8-1:0] regs_o
);

   localparam int ADDR_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 8192 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("spi_reg_port: NUM_REGS must be a power of two from 2 to 8192");
   end

   logic              cs_n_s;
   logic              sclk_rise;
   logic              sdi_s;
   logic              cfg_lsb;
   logic              cfg_bidir;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdio_in),
      .cs_n_s    (cs_n_s),
      .sclk_rise (sclk_rise),
      .sdi_s     (sdi_s)
   );

   spi_frame_engine #(.ADDR_W(ADDR_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (cs_n_s),
      .sclk_rise (sclk_rise),
      .sdi_s     (sdi_s),
      .cfg_lsb   (cfg_lsb),
      .cfg_bidir (cfg_bidir),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .sdo_out   (sdo_out),
      .sdo_oe    (sdo_oe),
      .sdio_out  (sdio_out),
      .sdio_oe   (sdio_oe)
   );

   spi_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .DEFAULTS (REG_DEFAULTS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .regs_flat (regs_o),
      .cfg_lsb   (cfg_lsb),
      .cfg_bidir (cfg_bidir)
   );

   assert_cfg_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (regs_o[5:0] == CFG_FIXED_LOW))
      else $error("configuration fixed bits changed");

   assert_cs_high_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !(sdo_oe || sdio_oe))
      else $error("data output driven without chip select");

endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;

   localparam int NREG = 16;
   localparam int HALF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdio_in = 1'b0;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic [NREG*8-1:0] regs_o;

   int checks = 0;
   int failures = 0;
   logic done = 1'b0;

   logic [7:0] model [NREG];
   logic lsb_mode = 1'b0;
   logic bidir_mode = 1'b0;

   always #2.5 clk = ~clk;

   spi_reg_port #(.NUM_REGS(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
      .regs_o(regs_o)
   );

   task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_defaults();
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      model[0] = 8'h10;
   endtask

   function automatic logic [NREG*8-1:0] image();
      logic [NREG*8-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   task automatic model_write(input int n, input logic [12:0] addr, input logic [31:0] wb);
      int a;
      a = int'(addr) % NREG;
      for (int j = 0; j < n; j++) begin
         if (a == 0) begin
            if (wb[8*j+5]) model_defaults();
            else model[0] = {wb[8*j+7], wb[8*j+6], 6'h10};
         end else begin
            model[a] = wb[8*j +: 8];
         end
         a = lsb_mode ? (a + 1) % NREG : (a + NREG - 1) % NREG;
      end
   endtask

   task automatic update_modes();
      lsb_mode   = model[0][6];
      bidir_mode = model[0][7];
   endtask

   // cut < 0: full transfer; otherwise chip select rises after cut clocks
   task automatic xfer(input logic rd, input int n, input logic [12:0] addr,
                       input logic [31:0] wb, input int extra, input int cut,
                       output logic [31:0] rb, output logic right_pin,
                       output logic wrong_pin, output logic extra_oe);
      logic [47:0] bits;
      logic [15:0] w;
      int total;
      int b;
      int k;
      logic pin;
      w = {rd, 2'(n - 1), addr};
      total = 16 + 8 * n;
      bits = '0;
      rb = '0;
      right_pin = 1'b1;
      wrong_pin = 1'b0;
      extra_oe = 1'b0;
      for (int i = 0; i < 16; i++) bits[i] = lsb_mode ? w[i] : w[15-i];
      for (int j = 0; j < n; j++)
         for (int bb = 0; bb < 8; bb++)
            bits[16 + 8*j + bb] = lsb_mode ? wb[8*j + bb] : wb[8*j + 7 - bb];
      cs_n = 1'b0;
      repeat (HALF) @(posedge clk);
      #1;
      for (int i = 0; i < total + extra; i++) begin
         if (cut >= 0 && i >= cut) break;
         sdio_in = (i < total) ? bits[i] : 1'b1;
         repeat (HALF) @(posedge clk);
         #1 sclk = 1'b1;
         repeat (HALF) @(posedge clk);
         #1;
         if (rd && i >= 15 && i < 15 + 8*n) begin
            k = i - 15;
            b = k % 8;
            pin = bidir_mode ? sdio_out : sdo_out;
            rb[8*(k/8) + (lsb_mode ? b : 7 - b)] = pin;
            if (bidir_mode ? !sdio_oe : !sdo_oe) right_pin = 1'b0;
            if (bidir_mode ? sdo_oe : sdio_oe) wrong_pin = 1'b1;
         end
         if (i >= total && (sdo_oe || sdio_oe)) extra_oe = 1'b1;
         sclk = 1'b0;
      end
      repeat (HALF) @(posedge clk);
      #1 cs_n = 1'b1;
      repeat (8) @(posedge clk);
      #1;
   endtask

   task automatic wr(input int n, input logic [12:0] addr, input logic [31:0] wb);
      logic [31:0] rb;
      logic a, b2, c;
      xfer(1'b0, n, addr, wb, 0, -1, rb, a, b2, c);
      model_write(n, addr, wb);
      update_modes();
   endtask

   task automatic rd_chk(input int n, input logic [12:0] addr, input string tag);
      logic [31:0] rb;
      logic [31:0] exp;
      logic rp, wp, eo;
      int a;
      exp = '0;
      a = int'(addr) % NREG;
      for (int j = 0; j < n; j++) begin
         exp[8*j +: 8] = model[a];
         a = lsb_mode ? (a + 1) % NREG : (a + NREG - 1) % NREG;
      end
      xfer(1'b1, n, addr, '0, 0, -1, rb, rp, wp, eo);
      chk(rb == exp, tag, rb, exp);
   endtask

   task automatic t_reset();
      chk(regs_o == image(), "R1 reset image", regs_o, image());
      chk(!sdo_oe && !sdio_oe, "R1 outputs idle", {sdo_oe, sdio_oe}, 0);
      rd_chk(1, 13'h0, "R11 config reads 0x10");
   endtask

   task automatic t_single();
      logic [31:0] rb;
      logic rp, wp, eo;
      wr(1, 13'h5, 32'hA5);
      chk(regs_o[5*8 +: 8] == 8'hA5, "R3 byte stored", regs_o[5*8 +: 8], 8'hA5);
      xfer(1'b1, 1, 13'h5, '0, 0, -1, rb, rp, wp, eo);
      chk(rb[7:0] == 8'hA5, "R4 read byte", rb[7:0], 8'hA5);
      chk(rp && !wp, "R7 unidirectional pins", {rp, wp}, 2'b10);
      wr(1, 13'h1F0B, 32'h3C);
      chk(regs_o[11*8 +: 8] == 8'h3C, "R2 high address bits ignored", regs_o[11*8 +: 8], 8'h3C);
   endtask

   task automatic t_msb_multi();
      wr(4, 13'h9, 32'h44332211);
      chk(regs_o == image(), "R5 descending four-byte write", regs_o, image());
      rd_chk(3, 13'h9, "R2 three-byte read");
      wr(1, 13'hF, 32'h77);
      rd_chk(2, 13'h0, "R5 descending wrap");
   endtask

   task automatic t_lsb();
      wr(1, 13'h0, 32'h40);
      chk(regs_o[7:0] == 8'h50, "R6 mode bit stored", regs_o[7:0], 8'h50);
      wr(3, 13'h2, 32'h3C2B1E);
      chk(regs_o == image(), "R6 ascending lsb-first write", regs_o, image());
      rd_chk(3, 13'h2, "R5 ascending read");
      rd_chk(2, 13'hF, "R5 ascending wrap");
      wr(1, 13'h0, 32'h00);
      rd_chk(1, 13'h5, "R6 back to msb-first");
   endtask

   task automatic t_bidir();
      logic [31:0] rb;
      logic rp, wp, eo;
      wr(1, 13'h0, 32'h80);
      xfer(1'b1, 1, 13'h5, '0, 0, -1, rb, rp, wp, eo);
      chk(rb[7:0] == model[5], "R7 bidirectional data", rb[7:0], model[5]);
      chk(rp && !wp, "R7 bidirectional pins", {rp, wp}, 2'b10);
      wr(1, 13'h0, 32'h00);
      chk(regs_o[7:0] == 8'h10, "R7 mode restored", regs_o[7:0], 8'h10);
   endtask

   task automatic t_abort();
      logic [31:0] rb;
      logic rp, wp, eo;
      xfer(1'b0, 1, 13'h3, 32'hEE, 0, 20, rb, rp, wp, eo);
      chk(regs_o == image(), "R8 partial byte discarded", regs_o, image());
      xfer(1'b1, 1, 13'h3, '0, 0, 8, rb, rp, wp, eo);
      rd_chk(1, 13'h9, "R8 transfer after abort");
      wr(1, 13'h3, 32'h5A);
      chk(regs_o[3*8 +: 8] == 8'h5A, "R8 write after abort", regs_o[3*8 +: 8], 8'h5A);
   endtask

   task automatic t_extra();
      logic [31:0] rb;
      logic rp, wp, eo;
      xfer(1'b0, 1, 13'hA, 32'h6D, 16, -1, rb, rp, wp, eo);
      model_write(1, 13'hA, 32'h6D);
      chk(regs_o == image(), "R10 extra clocks write nothing", regs_o, image());
      xfer(1'b1, 1, 13'hA, '0, 12, -1, rb, rp, wp, eo);
      chk(rb[7:0] == 8'h6D && !eo, "R10 no drive after count", {eo, rb[7:0]}, 9'h06D);
   endtask

   task automatic t_soft_reset();
      wr(1, 13'h0, 32'h60);
      chk(regs_o == image(), "R9 defaults restored", regs_o, image());
      chk(regs_o[7:0] == 8'h10, "R9 self-clearing bit", regs_o[7:0], 8'h10);
      rd_chk(1, 13'h9, "R9 register cleared");
   endtask

   initial begin
      model_defaults();
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      t_reset();
      t_single();
      t_msb_multi();
      t_lsb();
      t_bidir();
      t_abort();
      t_extra();
      t_soft_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule